// File: doc/BRIEF.md
# Self-Test Fetch Region Toggle Controller

During processor self-test this block decides where each bus cycle is served. Instruction fetches go to one of two on-chip code stores: a writable region whose instructions are rewritten with random fields as they are fetched, and a fixed read-only region that holds the supervisory test code. No fetch reaches external memory while the test runs. Data reads are answered by the signature compactor, and data writes feed into it.

One fixed trigger address moves execution between the regions. A trigger fetch from the fixed region always enters the writable region at its start offset. A trigger fetch from the writable region returns to the fixed region's start offset only when the low signature bits are all ones. Otherwise execution wraps to the start of the writable region. The number of signature bits compared is a parameter, which sets how often control returns to the fixed code.

Top module: `regionToggleCtl`

## Requirements
- R1: While `testEn` is low, `memEn`, `memSel`, `randWbEn`, `compress` and `sigRead` are 0 and `memAddr` is 0. Once `testEn` has been low at a clock edge, the region state is the fixed region.
- R2: The first fetch after `testEn` rises, to any address other than the trigger, is served from the fixed region (`memSel` = 0).
- R3: A fetch (`cycType` = 2'b01) to a non-trigger address has `memEn` = 1, `memSel` equal to the current region (1 = writable, 0 = fixed), and `memAddr` equal to the low `LOC_W` bits of `busAddr`. The region does not change.
- R4: A fetch of `TRIG_ADDR` while in the fixed region is served from the writable region at `WR_START`, and the region becomes writable.
- R5: A fetch of `TRIG_ADDR` while in the writable region, with the low `TOG_BITS` bits of `sigBits` all 1, is served from the fixed region at `FIX_START`, and the region becomes fixed.
- R6: A fetch of `TRIG_ADDR` while in the writable region with any of those bits 0 is served from the writable region at `WR_START`, and the region stays writable.
- R7: `randWbEn` is 1 exactly on enabled fetch cycles served from the writable region.
- R8: A read cycle (`cycType` = 2'b10) gives `sigRead` = 1, `compress` = 0, `memEn` = 0 and leaves the region unchanged.
- R9: Write cycles (`cycType` = 2'b11) and fetch cycles give `compress` = 1 and `sigRead` = 0. A write has `memEn` = 0 and leaves the region unchanged.
- R10: An idle cycle (`cycType` = 2'b00) drives every strobe to 0 and leaves the region unchanged.
- R11: With `TOG_BITS` = 0, every trigger fetch from the writable region returns to the fixed region at `FIX_START`, whatever the value of `sigBits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| testEn | input | 1 | Self-test enable |
| cycType | input | 2 | Bus cycle: 00 idle, 01 fetch, 10 read, 11 write |
| busAddr | input | ADDR_W | Processor bus address |
| sigBits | input | SIG_W | Low bits of the current compactor signature |
| memEn | output | 1 | Code store access for this cycle |
| memSel | output | 1 | Code store select: 1 writable, 0 fixed |
| memAddr | output | LOC_W | Offset inside the selected code store |
| randWbEn | output | 1 | Randomize-and-write-back enable |
| compress | output | 1 | Compactor absorbs bus data this cycle |
| sigRead | output | 1 | Compactor value drives the read data |

## Verification
The bench builds two instances. One uses the default three-bit toggle gate, so that taken and not-taken returns from the writable region occur with specific signature values. The other uses a zero-bit gate, so that every return from the writable region is unconditional (R11). Both instances receive the same directed sequences, then a long random stream in which trigger fetches are common and the enable drops from time to time. This exercises wraps, returns, and region resets that happen partway through the writable code.

// File: rtl/regionTogglePkg.sv
package regionTogglePkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_FETCH = 2'b01,
    CYC_READ  = 2'b10,
    CYC_WRITE = 2'b11
  } cycT;

  // Strobes from the control to the datapath and the block edge
  typedef struct packed {
    logic memEn;
    logic selWr;
    logic jumpWr;
    logic jumpFix;
    logic randEn;
    logic compress;
    logic sigRead;
  } strobeT;

endpackage

// File: rtl/togDatapath.sv
module togDatapath
  import regionTogglePkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LOC_W    = 6,
  parameter int unsigned SIG_W    = 4,
  parameter int unsigned TOG_BITS = 3,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h0030,
  parameter logic [LOC_W-1:0]  FIX_START = 6'h20,
  parameter logic [LOC_W-1:0]  WR_START  = 6'h01
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SIG_W-1:0]  sigBits,
  input  strobeT            strobes,
  output logic              trigHit,
  output logic              sigOk,
  output logic              memSel,
  output logic [LOC_W-1:0]  memAddr
);

  assign trigHit = (busAddr == TRIG_ADDR);

  // Gate that decides whether a return to the fixed code is allowed
  generate
    if (TOG_BITS == 0) begin : gAlways
      logic unusedSig;
      assign unusedSig = ^sigBits;
      assign sigOk = 1'b1;
    end else begin : gMask
      logic unusedSig;
      assign unusedSig = ^sigBits;
      assign sigOk = &sigBits[TOG_BITS-1:0];
    end
  endgenerate

  always_comb begin
    if (strobes.jumpWr)      memAddr = WR_START;
    else if (strobes.jumpFix) memAddr = FIX_START;
    else if (strobes.memEn)  memAddr = busAddr[LOC_W-1:0];
    else                     memAddr = '0;
  end

  assign memSel = strobes.selWr;

endmodule

// File: rtl/togControl.sv
module togControl
  import regionTogglePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       testEn,
  input  logic [1:0] cycType,
  input  logic       trigHit,
  input  logic       sigOk,
  output strobeT     strobes
);

  logic regionWr;
  cycT  cyc;

  assign cyc = cycT'(cycType);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 regionWr <= 1'b0;
    else if (!testEn)                          regionWr <= 1'b0;
    else if (cyc == CYC_FETCH && trigHit)      regionWr <= !(regionWr && sigOk);
  end

  always_comb begin
    strobes = '0;
    if (testEn) begin
      unique case (cyc)
        CYC_FETCH: begin
          strobes.memEn    = 1'b1;
          strobes.compress = 1'b1;
          if (trigHit) begin
            if (regionWr && sigOk) begin
              strobes.jumpFix = 1'b1;
            end else begin
              strobes.jumpWr = 1'b1;
              strobes.selWr  = 1'b1;
            end
          end else begin
            strobes.selWr = regionWr;
          end
          strobes.randEn = strobes.selWr;
        end
        CYC_READ:  strobes.sigRead  = 1'b1;
        CYC_WRITE: strobes.compress = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/regionToggleCtl.sv
module regionToggleCtl
  import regionTogglePkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LOC_W    = 6,
  parameter int unsigned SIG_W    = 4,
  parameter int unsigned TOG_BITS = 3,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h0030,
  parameter logic [LOC_W-1:0]  FIX_START = 6'h20,
  parameter logic [LOC_W-1:0]  WR_START  = 6'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEn,
  input  logic [1:0]        cycType,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [SIG_W-1:0]  sigBits,
  output logic              memEn,
  output logic              memSel,
  output logic [LOC_W-1:0]  memAddr,
  output logic              randWbEn,
  output logic              compress,
  output logic              sigRead
);

  strobeT strobes;
  logic   trigHit;
  logic   sigOk;

  togControl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .testEn  (testEn),
    .cycType (cycType),
    .trigHit (trigHit),
    .sigOk   (sigOk),
    .strobes (strobes)
  );

  togDatapath #(
    .ADDR_W(ADDR_W), .LOC_W(LOC_W), .SIG_W(SIG_W), .TOG_BITS(TOG_BITS),
    .TRIG_ADDR(TRIG_ADDR), .FIX_START(FIX_START), .WR_START(WR_START)
  ) dp_i (
    .busAddr (busAddr),
    .sigBits (sigBits),
    .strobes (strobes),
    .trigHit (trigHit),
    .sigOk   (sigOk),
    .memSel  (memSel),
    .memAddr (memAddr)
  );

  assign memEn    = strobes.memEn;
  assign randWbEn = strobes.randEn;
  assign compress = strobes.compress;
  assign sigRead  = strobes.sigRead;

endmodule

// File: rtl/regionToggleChk.sv
module regionToggleChk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned LOC_W    = 6,
  parameter int unsigned SIG_W    = 4,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h0030,
  parameter logic [LOC_W-1:0]  FIX_START = 6'h20,
  parameter logic [LOC_W-1:0]  WR_START  = 6'h01
) (
  input logic              clk,
  input logic              rstN,
  input logic              testEn,
  input logic [1:0]        cycType,
  input logic [ADDR_W-1:0] busAddr,
  input logic [SIG_W-1:0]  sigBits,
  input logic              memEn,
  input logic              memSel,
  input logic [LOC_W-1:0]  memAddr,
  input logic              randWbEn,
  input logic              compress,
  input logic              sigRead
);

  logic trigFetch;
  logic plainFetch;
  assign trigFetch  = testEn && cycType == 2'b01 && busAddr == TRIG_ADDR;
  assign plainFetch = testEn && cycType == 2'b01 && busAddr != TRIG_ADDR;

  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    !testEn |-> (!memEn && !memSel && !randWbEn && !compress && !sigRead && memAddr == '0));

  assert_start_fixed_R2: assert property (@(posedge clk) disable iff (!rstN)
    (plainFetch && !$past(testEn)) |-> !memSel);

  assert_enter_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    (trigFetch && memSel) |-> memAddr == WR_START);

  assert_return_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trigFetch && !memSel) |-> memAddr == FIX_START);

  assert_stay_writable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trigFetch && memSel) ##1 plainFetch |-> memSel);

  assert_rand_only_wr_R7: assert property (@(posedge clk) disable iff (!rstN)
    randWbEn |-> (memEn && memSel));

  assert_read_no_compress_R8: assert property (@(posedge clk) disable iff (!rstN)
    sigRead |-> (!compress && !memEn));

  assert_write_compress_R9: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && cycType == 2'b11) |-> (compress && !sigRead && !memEn));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == 2'b00) |-> $countones({memEn, randWbEn, compress, sigRead}) == 0);

endmodule

bind regionToggleCtl regionToggleChk #(
  .ADDR_W(ADDR_W), .LOC_W(LOC_W), .SIG_W(SIG_W),
  .TRIG_ADDR(TRIG_ADDR), .FIX_START(FIX_START), .WR_START(WR_START)
) chk_i (.*);

// File: tb/regionToggleCtl_tb.sv
`timescale 1ns/1ps
module regionToggleCtl_tb_top;

  localparam int AW = 16;
  localparam int LW = 6;
  localparam int SW = 4;
  localparam logic [AW-1:0] TRIG = 16'h0030;
  localparam logic [LW-1:0] FSTART = 6'h20;
  localparam logic [LW-1:0] WSTART = 6'h01;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testEn = 1'b0;
  logic [1:0] cycType = 2'b00;
  logic [AW-1:0] busAddr = '0;
  logic [SW-1:0] sigBits = '0;

  logic memEnA, memSelA, randA, compA, readA;
  logic [LW-1:0] addrA;
  logic memEnB, memSelB, randB, compB, readB;
  logic [LW-1:0] addrB;

  int checks = 0;
  int fails = 0;
  bit refA = 0;
  bit refB = 0;
  bit prevEn = 0;

  always #2 clk = ~clk;

  regionToggleCtl #(.TOG_BITS(3)) dut_i (
    .clk(clk), .rstN(rstN), .testEn(testEn), .cycType(cycType),
    .busAddr(busAddr), .sigBits(sigBits), .memEn(memEnA), .memSel(memSelA),
    .memAddr(addrA), .randWbEn(randA), .compress(compA), .sigRead(readA));

  regionToggleCtl #(.TOG_BITS(0)) dut0_i (
    .clk(clk), .rstN(rstN), .testEn(testEn), .cycType(cycType),
    .busAddr(busAddr), .sigBits(sigBits), .memEn(memEnB), .memSel(memSelB),
    .memAddr(addrB), .randWbEn(randB), .compress(compB), .sigRead(readB));

  // Reference: returns packed {memEn, memSel, memAddr, compress, sigRead},
  // the randomize enable, the next region and a requirement tag.
  task automatic model(input bit region, input int k, output logic [LW+3:0] exp,
                       output bit expRand, output bit nextRegion, output string tag);
    bit en, sel, m;
    logic [LW-1:0] a;
    en = 0; sel = 0; a = '0; nextRegion = region;
    exp = '0; expRand = 0;
    if (!testEn) begin
      tag = "R1"; nextRegion = 0;
    end else if (cycType == 2'b01) begin
      en = 1;
      if (busAddr == TRIG) begin
        m = 1;
        for (int i = 0; i < k; i++) if (!sigBits[i]) m = 0;
        if (!region) begin
          sel = 1; a = WSTART; nextRegion = 1; tag = "R4";
        end else if (m) begin
          sel = 0; a = FSTART; nextRegion = 0; tag = (k == 0) ? "R11" : "R5";
        end else begin
          sel = 1; a = WSTART; nextRegion = 1; tag = "R6";
        end
      end else begin
        sel = region; a = busAddr[LW-1:0]; tag = prevEn ? "R3" : "R2";
      end
      exp = {en, sel, a, 1'b1, 1'b0};
      expRand = sel;
    end else if (cycType == 2'b10) begin
      exp = {1'b0, 1'b0, {LW{1'b0}}, 1'b0, 1'b1}; tag = "R8";
    end else if (cycType == 2'b11) begin
      exp = {1'b0, 1'b0, {LW{1'b0}}, 1'b1, 1'b0}; tag = "R9";
    end else begin
      tag = "R10";
    end
  endtask

  task automatic compare(input string who, input string tag, input logic [LW+3:0] got,
                         input logic [LW+3:0] exp, input bit gotR, input bit expR);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: outputs got %h expected %h", tag, who, got, exp);
    end
    checks++;
    if (gotR !== expR) begin
      fails++;
      $display("FAIL R7 %s: randWbEn got %b expected %b", who, gotR, expR);
    end
  endtask

  // Drive one cycle at the falling edge, check, then let the rising edge update state
  task automatic step(input bit en, input logic [1:0] cyc, input logic [AW-1:0] addr,
                      input logic [SW-1:0] sig);
    logic [LW+3:0] e;
    bit er, nA, nB;
    string t;
    @(negedge clk);
    testEn = en; cycType = cyc; busAddr = addr; sigBits = sig;
    #1;
    model(refA, 3, e, er, nA, t);
    compare("k3", t, {memEnA, memSelA, addrA, compA, readA}, e, randA, er);
    model(refB, 0, e, er, nB, t);
    compare("k0", t, {memEnB, memSelB, addrB, compB, readB}, e, randB, er);
    @(posedge clk);
    if (rstN) begin
      refA = nA; refB = nB; prevEn = en;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    // Reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if ({memEnA, memSelA, addrA, randA, compA, readA} !== '0) begin
      fails++;
      $display("FAIL R1 reset: got %h expected 0", {memEnA, memSelA, addrA, randA, compA, readA});
    end
    @(negedge clk); rstN = 1;

    step(0, 2'b01, 16'h0012, 4'h0);      // R1 disabled fetch
    step(1, 2'b01, 16'h0012, 4'h0);      // R2 first fetch fixed
    step(1, 2'b00, 16'h0000, 4'h0);      // R10
    step(1, 2'b10, 16'h0100, 4'h0);      // R8
    step(1, 2'b11, 16'h0100, 4'h0);      // R9
    step(1, 2'b01, 16'h0005, 4'h0);      // R3 fixed
    step(1, 2'b01, TRIG, 4'h0);          // R4 enter writable
    step(1, 2'b01, 16'h0007, 4'h0);      // R3 writable, R7
    step(1, 2'b01, TRIG, 4'h3);          // R6 wrap (k3), R11 return (k0)
    step(1, 2'b01, 16'h0009, 4'h0);      // R3
    step(1, 2'b01, TRIG, 4'h6);          // R6 bit0 clear
    step(1, 2'b01, TRIG, 4'h7);          // R5 return
    step(1, 2'b01, 16'h000A, 4'h0);      // R3 fixed again
    step(1, 2'b01, TRIG, 4'hF);          // R4
    step(1, 2'b10, TRIG, 4'hF);          // R8 read of trigger address: no switch
    step(1, 2'b11, TRIG, 4'hF);          // R9 write of trigger address: no switch
    step(1, 2'b01, 16'h0004, 4'h0);      // still writable
    step(0, 2'b00, 16'h0000, 4'h0);      // R1 region drops
    step(1, 2'b01, 16'h0004, 4'h0);      // R2 fixed after re-enable

    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a;
      bit en;
      en = ($urandom_range(0, 39) != 0);
      a = ($urandom_range(0, 2) == 0) ? TRIG : AW'($urandom_range(0, 16'hFFFF));
      step(en, 2'($urandom_range(0, 3)), a, SW'($urandom_range(0, 15)));
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule